// File: doc/BRIEF.md
# Nonvolatile Setting Store/Restore Sequencer

This block keeps the nonvolatile copy of a wiper setting and moves values between that copy and the live wiper register. When power comes up, the wiper is first driven to midscale. A timed load from the nonvolatile image then replaces it. After that, a command interface can request three things: a timed store (wiper to image), a timed restore (image to wiper), or a no-operation. A separate direct port writes the image in a single cycle.

A commanded restore leaves the block in an elevated read-power state, and only a later no-operation clears it. For a fixed window after power-on, nothing may write the image. Requests that arrive while an operation runs, or inside that window, are discarded and set a sticky error flag. A read port returns the wiper, the image, or one of two constant tolerance bytes. All delays are parameters counted in clock cycles.

Top module: `nv_setting_seq`

## Requirements
- R1: While rst_ni is low, wiper_o is 0x80, busy_o is 1, read_pwr_o is 0 and err_o is 0.
- R2: The image holds 0x80 at first power-on, and it keeps its contents across any later assertion of rst_ni.
- R3: After reset is released, busy_o stays 1 and wiper_o stays 0x80 for RESTORE_CYC-1 rising edges. On edge RESTORE_CYC, wiper_o takes the image value and busy_o falls. read_pwr_o stays 0 throughout.
- R4: A restore accepted at edge k keeps busy_o high, and wiper_o unchanged, up to edge k+RESTORE_CYC-1. On edge k+RESTORE_CYC, wiper_o takes the image value and busy_o falls.
- R5: An accepted restore sets read_pwr_o on its accepting edge. read_pwr_o stays set until a no-operation is sampled, which clears it on that edge.
- R6: A store accepted at edge k keeps busy_o high, and leaves the image unchanged, up to edge k+STORE_CYC-1. On edge k+STORE_CYC, the image takes wiper_o and busy_o falls.
- R7: A direct write sampled while the block is idle and unlocked loads nv_wr_data_i into the image on that edge.
- R8: Store, restore and write requests sampled on edges 1 to LOCK_CYC after reset release are dropped, and each one sets err_o. The first edge that can accept a request is LOCK_CYC+1.
- R9: A store, restore or write request sampled while busy_o is 1 is dropped: the wiper and image are unaffected, and err_o is set.
- R10: Once err_o is set, it stays set until rst_ni is asserted.
- R11: rd_data_o is selected by rd_addr_i as follows:
  - address 0 returns the wiper;
  - address 1 returns the image;
  - address 30 returns TOL_INT (bit 7 is the sign, 1 meaning minus; bits 6:0 are the integer percent);
  - address 31 returns TOL_FRAC (the fractional percent in steps of 1/256);
  - every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous |
| store_req_i | input | 1 | Request to copy the wiper into the image |
| restore_req_i | input | 1 | Request to copy the image into the wiper |
| nop_req_i | input | 1 | No-operation; clears the read-power state |
| nv_wr_i | input | 1 | Direct image write strobe |
| nv_wr_data_i | input | DW | Direct image write data |
| rd_addr_i | input | AW | Read location select |
| rd_data_o | output | DW | Read data for the selected location |
| wiper_o | output | DW | Current wiper code |
| busy_o | output | 1 | An operation (power-up load, restore or store) is in progress |
| read_pwr_o | output | 1 | Elevated read-power state after a commanded restore |
| err_o | output | 1 | Sticky flag set by a dropped request |

## Verification
The hardest state to reach is a power-up load that actually changes the wiper. The image resets to midscale only once, so the load must follow a second reset, after the image has been rewritten through the direct port; the bench does this and watches each edge of the load. The lockout boundary is probed with one write at the last locked edge and another at the first open edge. The restore path is swept over all 256 codes, checking that the wiper holds its old value until the completing edge.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_LOAD,
    OP_SAVE
  } nv_op_e;
endpackage

// File: rtl/nv_cycle_timer.sv
module nv_cycle_timer #(
  parameter int unsigned CW = 8,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          run_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= RST_VAL;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign run_o  = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/nv_image_store.sv
module nv_image_store #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] FACTORY = '0
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [DW-1:0] wd_i,
  output logic [DW-1:0] img_o
);
  // no reset: contents survive power-on reset
  logic [DW-1:0] img_q = FACTORY;

  always_ff @(posedge clk_i) begin
    if (we_i) img_q <= wd_i;
  end

  assign img_o = img_q;
endmodule

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl
  import nv_seq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned RESTORE_CYC = 4,
  parameter int unsigned STORE_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          store_req_i,
  input  logic          restore_req_i,
  input  logic          nop_req_i,
  input  logic          nv_wr_i,
  input  logic [DW-1:0] nv_wr_data_i,
  input  logic          locked_i,
  input  logic          tmr_last_i,
  input  logic [DW-1:0] img_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          img_we_o,
  output logic [DW-1:0] img_wd_o,
  output logic [DW-1:0] wiper_o,
  output logic          busy_o,
  output logic          read_pwr_o,
  output logic          err_o
);
  localparam logic [DW-1:0] MIDSCALE = DW'(1) << (DW - 1);

  nv_op_e        op_q;
  logic [DW-1:0] wiper_q;
  logic          rpwr_q, err_q;
  logic          open_w, acc_ld, acc_sv, acc_wr, any_req, done_w;

  assign busy_o  = (op_q != OP_IDLE);
  assign open_w  = !busy_o && !locked_i;
  // priority: restore, then store, then direct write
  assign acc_ld  = restore_req_i && open_w;
  assign acc_sv  = store_req_i && open_w && !restore_req_i;
  assign acc_wr  = nv_wr_i && open_w && !restore_req_i && !store_req_i;
  assign any_req = restore_req_i || store_req_i || nv_wr_i;
  assign done_w  = busy_o && tmr_last_i;

  assign tmr_load_o = acc_ld || acc_sv;
  assign tmr_val_o  = acc_ld ? CW'(RESTORE_CYC) : CW'(STORE_CYC);
  assign img_we_o   = acc_wr || (done_w && op_q == OP_SAVE);
  assign img_wd_o   = acc_wr ? nv_wr_data_i : wiper_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_LOAD;
      wiper_q <= MIDSCALE;
      rpwr_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (acc_ld)      op_q <= OP_LOAD;
      else if (acc_sv) op_q <= OP_SAVE;
      else if (done_w) op_q <= OP_IDLE;

      if (done_w && op_q == OP_LOAD) wiper_q <= img_i;

      if (acc_ld)         rpwr_q <= 1'b1;
      else if (nop_req_i) rpwr_q <= 1'b0;

      if (any_req && !(acc_ld || acc_sv || acc_wr)) err_q <= 1'b1;
    end
  end

  assign wiper_o    = wiper_q;
  assign read_pwr_o = rpwr_q;
  assign err_o      = err_q;
endmodule

// File: rtl/nv_setting_seq.sv
module nv_setting_seq #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 5,
  parameter int unsigned RESTORE_CYC = 60000,
  parameter int unsigned STORE_CYC = 5200000,
  parameter int unsigned LOCK_CYC = 108000,
  parameter logic [DW-1:0] TOL_INT = 8'h00,
  parameter logic [DW-1:0] TOL_FRAC = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          store_req_i,
  input  logic          restore_req_i,
  input  logic          nop_req_i,
  input  logic          nv_wr_i,
  input  logic [DW-1:0] nv_wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] wiper_o,
  output logic          busy_o,
  output logic          read_pwr_o,
  output logic          err_o
);
  localparam int unsigned MAX_OP = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
  localparam int unsigned MAXC   = (LOCK_CYC > MAX_OP) ? LOCK_CYC : MAX_OP;
  localparam int unsigned CW     = $clog2(MAXC + 1);
  localparam logic [DW-1:0] MIDSCALE = DW'(1) << (DW - 1);
  localparam logic [AW-1:0] A_WIPER  = AW'(0);
  localparam logic [AW-1:0] A_IMAGE  = AW'(1);
  localparam logic [AW-1:0] A_TOLHI  = {AW{1'b1}} - AW'(1);
  localparam logic [AW-1:0] A_TOLLO  = {AW{1'b1}};

  logic          tmr_load, tmr_last, tmr_run_unused;
  logic [CW-1:0] tmr_val;
  logic          lock_run, lock_last_unused;
  logic          img_we;
  logic [DW-1:0] img_wd, img_w;

  nv_cycle_timer #(.CW(CW), .RST_VAL(CW'(RESTORE_CYC))) u_op_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .load_val_i(tmr_val),
    .run_o(tmr_run_unused), .last_o(tmr_last)
  );

  nv_cycle_timer #(.CW(CW), .RST_VAL(CW'(LOCK_CYC))) u_lock_tmr (
    .clk_i, .rst_ni,
    .load_i(1'b0), .load_val_i('0),
    .run_o(lock_run), .last_o(lock_last_unused)
  );

  nv_image_store #(.DW(DW), .FACTORY(MIDSCALE)) u_img (
    .clk_i, .we_i(img_we), .wd_i(img_wd), .img_o(img_w)
  );

  nv_seq_ctrl #(
    .DW(DW), .CW(CW), .RESTORE_CYC(RESTORE_CYC), .STORE_CYC(STORE_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .store_req_i, .restore_req_i, .nop_req_i, .nv_wr_i, .nv_wr_data_i,
    .locked_i(lock_run), .tmr_last_i(tmr_last), .img_i(img_w),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .img_we_o(img_we), .img_wd_o(img_wd),
    .wiper_o, .busy_o, .read_pwr_o, .err_o
  );

  always_comb begin
    unique case (rd_addr_i)
      A_WIPER: rd_data_o = wiper_o;
      A_IMAGE: rd_data_o = img_w;
      A_TOLHI: rd_data_o = TOL_INT;
      A_TOLLO: rd_data_o = TOL_FRAC;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/nv_setting_seq_chk.sv
module nv_setting_seq_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          store_req_i,
  input logic          restore_req_i,
  input logic          nop_req_i,
  input logic          nv_wr_i,
  input logic [DW-1:0] wiper_o,
  input logic [DW-1:0] img_i,
  input logic          busy_o,
  input logic          read_pwr_o,
  input logic          err_o
);
  // R4
  wiper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> $fell(busy_o));
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R5
  rpwr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(read_pwr_o) |-> busy_o);
  // R5
  rpwr_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nop_req_i && !restore_req_i) |=> !read_pwr_o);
  // R6
  img_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(img_i) |-> ($past(nv_wr_i) || $fell(busy_o)));
  // R9
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && store_req_i) |=> err_o);
endmodule

bind nv_setting_seq nv_setting_seq_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .store_req_i(store_req_i), .restore_req_i(restore_req_i),
  .nop_req_i(nop_req_i), .nv_wr_i(nv_wr_i),
  .wiper_o(wiper_o), .img_i(img_w),
  .busy_o(busy_o), .read_pwr_o(read_pwr_o), .err_o(err_o)
);

// File: tb/nv_setting_seq_tb.sv
`timescale 1ns/1ps
module nv_setting_seq_tb;
  localparam int RC = 5;
  localparam int SC = 9;
  localparam int LC = 12;
  localparam logic [7:0] TI = 8'h83;
  localparam logic [7:0] TF = 8'h40;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       store_req_i, restore_req_i, nop_req_i, nv_wr_i;
  logic [7:0] nv_wr_data_i;
  logic [4:0] rd_addr_i;
  logic [7:0] rd_data_o, wiper_o;
  logic       busy_o, read_pwr_o, err_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  nv_setting_seq #(
    .DW(8), .AW(5), .RESTORE_CYC(RC), .STORE_CYC(SC), .LOCK_CYC(LC),
    .TOL_INT(TI), .TOL_FRAC(TF)
  ) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nb();
    @(negedge clk_i);
  endtask

  task automatic powerup(input logic [7:0] img);
    for (int e = 1; e <= RC; e++) begin
      nb();
      chk("R3 busy", busy_o, (e < RC));
      chk("R3 wiper", wiper_o, (e < RC) ? 8'h80 : img);
      chk("R3 read_pwr", read_pwr_o, 1'b0);
    end
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    nv_wr_i = 1'b1; nv_wr_data_i = d;
    nb();
    nv_wr_i = 1'b0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R0 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    rst_ni = 1'b0; store_req_i = 0; restore_req_i = 0; nop_req_i = 0;
    nv_wr_i = 0; nv_wr_data_i = 0; rd_addr_i = 5'd1;
    repeat (3) nb();
    chk("R1 wiper", wiper_o, 8'h80);
    chk("R1 busy", busy_o, 1'b1);
    chk("R1 read_pwr", read_pwr_o, 1'b0);
    chk("R1 err", err_o, 1'b0);
    chk("R2 factory", rd_data_o, 8'h80);
    rst_ni = 1'b1;
    powerup(8'h80);

    // R8 lockout: edge 6 locked
    pulse_wr(8'h11);
    chk("R8 err", err_o, 1'b1);
    chk("R8 image", rd_data_o, 8'h80);
    repeat (5) nb();
    pulse_wr(8'h22);                     // edge LC, still locked
    chk("R8 last locked edge", rd_data_o, 8'h80);
    pulse_wr(8'h3C);                     // edge LC+1, open
    chk("R7 write", rd_data_o, 8'h3C);
    chk("R10 sticky", err_o, 1'b1);
    chk("R7 wiper untouched", wiper_o, 8'h80);

    rst_ni = 1'b0; nb(); nb();
    chk("R1 err cleared", err_o, 1'b0);
    chk("R2 retained", rd_data_o, 8'h3C);
    rst_ni = 1'b1;
    powerup(8'h3C);
    repeat (LC - RC) nb();

    for (int a = 0; a < 32; a++) begin
      logic [7:0] ex;
      nb();
      rd_addr_i = 5'(a);
      #0.2;
      ex = (a == 0) ? wiper_o : (a == 1) ? 8'h3C : (a == 30) ? TI : (a == 31) ? TF : 8'h00;
      chk("R11 read map", rd_data_o, ex);
    end
    rd_addr_i = 5'd1;

    prev = 8'h3C;
    for (int v = 0; v < 256; v++) begin
      pulse_wr(8'(v));
      restore_req_i = 1'b1;
      nb();
      restore_req_i = 1'b0;
      chk("R5 set", read_pwr_o, 1'b1);
      for (int i = 1; i <= RC; i++) begin
        nb();
        chk("R4 wiper", wiper_o, (i < RC) ? prev : 8'(v));
        chk("R4 busy", busy_o, (i < RC));
      end
      chk("R5 hold", read_pwr_o, 1'b1);
      nop_req_i = 1'b1; nb(); nop_req_i = 1'b0;
      chk("R5 nop", read_pwr_o, 1'b0);
      prev = 8'(v);
    end
    chk("R9 no err yet", err_o, 1'b0);

    restore_req_i = 1'b1; nb(); restore_req_i = 1'b0;
    nv_wr_i = 1'b1; nv_wr_data_i = 8'h00; nb(); nv_wr_i = 1'b0;
    chk("R9 err", err_o, 1'b1);
    repeat (RC - 1) nb();
    chk("R9 image kept", rd_data_o, 8'hFF);
    chk("R9 wiper", wiper_o, 8'hFF);
    chk("R9 idle", busy_o, 1'b0);

    rst_ni = 1'b0; nb(); rst_ni = 1'b1;
    powerup(8'hFF);
    repeat (LC - RC) nb();
    pulse_wr(8'h5A);
    chk("R7 write", rd_data_o, 8'h5A);
    store_req_i = 1'b1; nb(); store_req_i = 1'b0;
    for (int i = 1; i <= SC; i++) begin
      nb();
      chk("R6 image", rd_data_o, (i < SC) ? 8'h5A : 8'hFF);
      chk("R6 busy", busy_o, (i < SC));
    end
    chk("R6 no err", err_o, 1'b0);
    chk("R6 read_pwr", read_pwr_o, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule